// File: doc/BRIEF.md
# Instruction Address Sequencer with Return Stack

This block holds the 13-bit instruction address of a small microcontroller core and picks the address of the next instruction. The instruction decoder drives one-cycle request strobes into it: sequential step, goto, call, return, interrupt entry and a write to the low address byte. An 8-entry return stack is built in. Call and interrupt entry push onto it, and return pops from it. The decoder sees the current address and the low address byte. The program memory array and interrupt arbitration sit outside this block.

The five upper address bits are never written directly. A separate 5-bit holding register, written by its own strobe, supplies them when the low byte is written. Bits 4:3 of the same register supply address bits 12:11 on a goto or call. The `half_space` input selects a 4K-word program space. When it is high, every address the block loads has bit 12 cleared, so addresses past the implemented size wrap to the start.

Top module: `instr_addr_unit`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge) the address is 0000h, the low byte reads 00h and the holding register is 0.
- R2: `step` adds one to the address at the next edge. While `halted` is high, `step` has no effect and the address holds.
- R3: `irq_enter` loads address 0004h and pushes the current address onto the return stack.
- R4: `jmp_go` (goto) and `jmp_call` (call) load the address {holding[4:3], `jmp_lit`[10:0]}. A call also pushes the address plus one. A goto does not touch the stack.
- R5: `ret_pop` loads the address from the top of the return stack and removes that entry.
- R6: `low_we` loads the address {holding[4:0], `low_din`[7:0]}. When `hold_we` is strobed in the same cycle, the load uses the holding value from before that write.
- R7: A write to the holding register alone leaves the address unchanged.
- R8: The stack is 8 entries and circular. A ninth push overwrites the oldest entry, and a pop past the last valid entry returns whatever entry the pointer wraps onto. No overflow or underflow status exists.
- R9: When `half_space` is high, bit 12 of every loaded address is 0, and a step from 0FFFh gives 0000h. When it is low, a step from 1FFFh gives 0000h.
- R10: When several requests are strobed together, the highest one wins, in this order: `irq_enter`, `ret_pop`, `jmp_go`/`jmp_call`, `low_we`, `step`. Only the winning request acts on the stack.
- R11: `pc_low` always equals bits 7:0 of `pc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| half_space | input | 1 | 1 selects a 4K-word program space |
| step | input | 1 | Sequential increment request |
| halted | input | 1 | Core is asleep; blocks `step` |
| irq_enter | input | 1 | Interrupt entry request |
| jmp_go | input | 1 | Goto request |
| jmp_call | input | 1 | Call request |
| jmp_lit | input | 11 | Literal target of goto/call |
| ret_pop | input | 1 | Return request (all return kinds) |
| low_we | input | 1 | Low address byte write strobe |
| low_din | input | 8 | Data for the low byte write |
| hold_we | input | 1 | Holding register write strobe |
| hold_din | input | 5 | Data for the holding register |
| pc | output | 13 | Current instruction address |
| pc_low | output | 8 | Readable low address byte |

## Verification
Several requests can arrive in the same cycle. The bench strobes interrupt entry together with a return, a call and a step. It also strobes a return with a call, a call with a low-byte write, and a low-byte write with a step. Each result is judged against the fixed priority order, and the return stack is then drained to confirm that only the winning request pushed or popped. A second same-cycle case is a low-byte write together with a holding-register write: the loaded upper bits must come from the old holding value, and the new value must appear only on the following low-byte write.

// File: rtl/instr_addr_unit.sv
module instr_addr_unit #(
  parameter int AW    = 13,
  parameter int LITW  = 11,
  parameter int LATW  = 5,
  parameter int DEPTH = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            half_space,
  input  logic            step,
  input  logic            halted,
  input  logic            irq_enter,
  input  logic            jmp_go,
  input  logic            jmp_call,
  input  logic [LITW-1:0] jmp_lit,
  input  logic            ret_pop,
  input  logic            low_we,
  input  logic [7:0]      low_din,
  input  logic            hold_we,
  input  logic [LATW-1:0] hold_din,
  output logic [AW-1:0]   pc,
  output logic [7:0]      pc_low
);
  localparam int SPW = $clog2(DEPTH);
  localparam logic [AW-1:0] IRQ_VEC = AW'(4);

  logic [AW-1:0]   pc_q, pc_nxt, pc_inc, addr_mask, push_val;
  logic [LATW-1:0] hold_q;
  logic [SPW-1:0]  sp_q, sp_top;
  logic [AW-1:0]   stk [DEPTH];
  logic            push_en, pop_en, jump;

  assign addr_mask = half_space ? {1'b0, {(AW-1){1'b1}}} : {AW{1'b1}};
  assign pc_inc    = pc_q + 1'b1;
  assign jump      = jmp_go | jmp_call;
  assign pop_en    = !irq_enter && ret_pop;
  assign push_en   = irq_enter || (!ret_pop && jmp_call);
  assign push_val  = (irq_enter ? pc_q : pc_inc) & addr_mask;
  assign sp_top    = sp_q - 1'b1;

  always_comb begin
    if (irq_enter)            pc_nxt = IRQ_VEC;
    else if (ret_pop)         pc_nxt = stk[sp_top];
    else if (jump)            pc_nxt = {hold_q[LATW-1 -: AW-LITW], jmp_lit};
    else if (low_we)          pc_nxt = {hold_q, low_din};
    else if (step && !halted) pc_nxt = pc_inc;
    else                      pc_nxt = pc_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q   <= '0;
      hold_q <= '0;
      sp_q   <= '0;
      for (int i = 0; i < DEPTH; i++) stk[i] <= '0;
    end else begin
      pc_q <= pc_nxt & addr_mask;
      if (hold_we) hold_q <= hold_din;
      if (push_en) begin
        stk[sp_q] <= push_val;
        sp_q      <= sp_q + 1'b1;
      end else if (pop_en) begin
        sp_q <= sp_top;
      end
    end
  end

  assign pc     = pc_q;
  assign pc_low = pc_q[7:0];

  assert_irq_vec_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_enter |=> pc == IRQ_VEC);

  assert_halt_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !irq_enter && !ret_pop && !jump && !low_we && !$changed(half_space)) |=> $stable(pc));

  assert_hold_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_we && !step && !irq_enter && !ret_pop && !jump && !low_we && !$changed(half_space)) |=> $stable(pc));

  assert_call_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (jump && !irq_enter && !ret_pop) |=> pc[LITW-1:0] == $past(jmp_lit));

  assert_low_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (low_we && !jump && !irq_enter && !ret_pop) |=> pc[7:0] == $past(low_din));

  assert_half_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (half_space && $past(half_space)) |-> !pc[AW-1]);
endmodule

// File: tb/instr_addr_unit_tb.sv
module instr_addr_unit_tb;
  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic        r_half = 0, r_step = 0, r_halt = 0, r_irq = 0, r_go = 0, r_call = 0;
  logic        r_ret = 0, r_lw = 0, r_hw = 0;
  logic [10:0] r_lit = '0;
  logic [7:0]  r_ldin = '0;
  logic [4:0]  r_hdin = '0;
  logic [12:0] pc;
  logic [7:0]  pc_low;

  instr_addr_unit u_dut (
    .clk(clk), .rst_n(rst_n), .half_space(r_half), .step(r_step), .halted(r_halt),
    .irq_enter(r_irq), .jmp_go(r_go), .jmp_call(r_call), .jmp_lit(r_lit),
    .ret_pop(r_ret), .low_we(r_lw), .low_din(r_ldin), .hold_we(r_hw),
    .hold_din(r_hdin), .pc(pc), .pc_low(pc_low));

  int checks = 0, errors = 0;
  logic [12:0] exp_q [$];
  string       tag_q [$];

  logic [12:0] m_pc = '0;
  logic [4:0]  m_lat = '0;
  logic [12:0] m_stk [8];
  logic [2:0]  m_sp = '0;

  task automatic m_push(input logic [12:0] v);
    m_stk[m_sp] = v;
    m_sp = m_sp + 1'b1;
  endtask

  task automatic clear_req();
    r_step = 0; r_halt = 0; r_irq = 0; r_go = 0; r_call = 0;
    r_ret = 0; r_lw = 0; r_hw = 0;
  endtask

  task automatic fire(input string tag);
    logic [12:0] mask, n;
    mask = r_half ? 13'h0FFF : 13'h1FFF;
    if (r_irq) begin m_push(m_pc & mask); n = 13'h0004; end
    else if (r_ret) begin m_sp = m_sp - 1'b1; n = m_stk[m_sp]; end
    else if (r_go || r_call) begin
      if (r_call) m_push((m_pc + 13'd1) & mask);
      n = {m_lat[4:3], r_lit};
    end
    else if (r_lw) n = {m_lat, r_ldin};
    else if (r_step && !r_halt) n = m_pc + 13'd1;
    else n = m_pc;
    m_pc = n & mask;
    if (r_hw) m_lat = r_hdin;
    @(posedge clk); #1;
    clear_req();
    exp_q.push_back(m_pc);
    tag_q.push_back(tag);
  endtask

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [12:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (pc !== e || pc_low !== e[7:0]) begin
        errors++;
        $display("FAIL %s (R11 low byte too): pc=%h low=%h expected pc=%h low=%h", t, pc, pc_low, e, e[7:0]);
      end
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) m_stk[i] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    checks++;
    if (pc !== 13'h0000 || pc_low !== 8'h00) begin
      errors++;
      $display("FAIL R1 reset: pc=%h low=%h expected pc=0000 low=00", pc, pc_low);
    end
    @(posedge clk); #1;

    r_step = 1; fire("R2 step");
    r_step = 1; fire("R2 step");
    r_step = 1; fire("R2 step");
    r_step = 1; r_halt = 1; fire("R2 step while halted");
    r_hw = 1; r_hdin = 5'b11010; fire("R7 holding write alone");
    r_call = 1; r_lit = 11'h123; fire("R4 call target");
    r_step = 1; fire("R2 step after call");
    r_go = 1; r_lit = 11'h7FF; fire("R4 goto target");
    r_step = 1; fire("R9 full-space wrap");
    r_irq = 1; fire("R3 interrupt vector");
    r_ret = 1; fire("R5 return from interrupt");
    r_ret = 1; fire("R5 return from call");
    r_lw = 1; r_ldin = 8'hAB; r_hw = 1; r_hdin = 5'b00001; fire("R6 low write uses old holding");
    r_lw = 1; r_ldin = 8'h10; fire("R6 low write uses new holding");

    r_irq = 1; r_ret = 1; r_call = 1; r_lit = 11'h055; r_step = 1; fire("R10 irq wins");
    r_ret = 1; r_call = 1; r_lit = 11'h066; fire("R10 return beats call");
    r_call = 1; r_lit = 11'h0AA; r_lw = 1; r_ldin = 8'h33; fire("R10 call beats low write");
    r_lw = 1; r_ldin = 8'h77; r_step = 1; fire("R10 low write beats step");
    r_ret = 1; fire("R10 stack after mixed requests");

    for (int i = 0; i < 9; i++) begin
      r_call = 1; r_lit = 11'(11'h100 + 11'(i * 16)); fire("R8 push");
    end
    for (int i = 0; i < 10; i++) begin
      r_ret = 1; fire("R8 circular pop");
    end

    r_half = 1;
    r_hw = 1; r_hdin = 5'b11111; fire("R9 mask on entering 4K space");
    r_go = 1; r_lit = 11'h7FF; fire("R9 goto masked");
    r_step = 1; fire("R9 4K wrap");
    r_lw = 1; r_ldin = 8'h55; fire("R9 low write masked");
    r_call = 1; r_lit = 11'h3C0; fire("R9 call masked");
    r_ret = 1; fire("R9 masked return address");
    r_half = 0;
    r_step = 1; fire("R2 step back in 8K space");

    @(negedge clk); @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule